// File: doc/BRIEF.md
# CRC7 Command Checksum Unit

This unit produces the 7-bit checksum that ends each command frame sent over a byte-wide serial link. Bytes enter one per cycle through a valid/ready handshake. A start pulse opens a frame and loads the seed. A last flag marks the final covered byte. One cycle after that byte is taken, the unit presents the checksum as a full byte: the 7-bit CRC in bits 7:1 and a zero in bit 0. The unit holds that byte until the next start.

The CRC uses the generator x^7 + x^3 + 1. The register starts at all ones for every frame. Each byte is folded in most significant bit first, and every byte of the command except the checksum byte itself is covered. A framer that runs without checksums clears the enable input. The unit then reports no checksum byte, and the framer sends a frame one byte shorter.

Top module: `crc7_cmd_unit`

## Requirements
- R1: After reset, crc_valid_o is 0, crc_byte_o is 0x00 and ready_o is 0.
- R2: The checksum equals the CRC with polynomial 0x09 (x^7+x^3+1) and seed 0x7F, updated per byte as next = f((crc << 1) XOR byte), bits taken MSB first. For the covered bytes 0xCA,0x00,0x00,0x00 the emitted byte is 0xB8.
- R3: crc_byte_o carries the CRC in bits 7:1, and bit 0 is always 0.
- R4: crc_valid_o rises in the cycle after the byte flagged with last_i is accepted. It and crc_byte_o then hold until the next start_i.
- R5: A start_i in the same cycle as a valid byte reseeds first and then absorbs that byte, so a frame may begin with its first byte.
- R6: A start_i without an accepted last byte clears crc_valid_o and restarts the CRC, discarding any partly accumulated frame.
- R7: If crc_en_i is 0 when the last byte is accepted, crc_valid_o stays 0 and crc_byte_o is 0x00.
- R8: Cycles with valid_i low inside a frame do not change the result.
- R9: Outside a frame (before the first start or after the last byte), ready_o is 0 unless start_i is high, and offered bytes do not change crc_byte_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a frame and loads the seed |
| valid_i | input | 1 | A byte is offered on data_i |
| data_i | input | 8 | Command byte |
| last_i | input | 1 | The offered byte is the last covered byte |
| crc_en_i | input | 1 | 1: produce a checksum byte; 0: frame without checksum |
| ready_o | output | 1 | The byte offered this cycle is accepted |
| crc_valid_o | output | 1 | crc_byte_o holds a finished checksum |
| crc_byte_o | output | 8 | Checksum byte, CRC in bits 7:1 and 0 in bit 0 |

## Verification
A fixed single-word-read command with a known checksum shows that the polynomial, seed and bit order all agree. Random frames of 4 to 8 bytes, checked against a bitwise model in the bench, cover a wide spread of register states. Frames with idle gaps separate handshake gating from data absorption. Frames started with and without a byte in the start cycle show that the seed is applied before the first byte. A restart in mid-frame, bytes offered after the last byte, and a frame with the checksum disabled each check that stale state is discarded or left untouched.

// File: rtl/crc7_pkg.sv
package crc7_pkg;
  localparam int unsigned CRC_W  = 7;
  localparam int unsigned BYTE_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;
  localparam logic [CRC_W-1:0] CRC_SEED = 7'h7F;
endpackage

// File: rtl/crc7_step.sv
// One full byte through the LFSR, MSB first, unrolled.
module crc7_step #(
  parameter int unsigned CW = crc7_pkg::CRC_W,
  parameter int unsigned DW = crc7_pkg::BYTE_W,
  parameter logic [CW-1:0] POLY = crc7_pkg::CRC_POLY
) (
  input  logic [CW-1:0] crc_i,
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] crc_o
);
  always_comb begin
    logic [CW-1:0] r;
    logic fb;
    r = crc_i;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = r[CW-1] ^ data_i[i];
      r  = {r[CW-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_o = r;
  end
endmodule

// File: rtl/crc7_acc.sv
module crc7_acc #(
  parameter int unsigned CW = crc7_pkg::CRC_W,
  parameter int unsigned DW = crc7_pkg::BYTE_W,
  parameter logic [CW-1:0] POLY = crc7_pkg::CRC_POLY,
  parameter logic [CW-1:0] SEED = crc7_pkg::CRC_SEED
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          take_i,
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] crc_next_o
);
  logic [CW-1:0] crc_q, base;

  // seed takes effect before a byte offered in the start cycle
  assign base = start_i ? SEED : crc_q;

  crc7_step #(.CW(CW), .DW(DW), .POLY(POLY)) u_step (
    .crc_i (base),
    .data_i(data_i),
    .crc_o (crc_next_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= SEED;
    else if (take_i)  crc_q <= crc_next_o;
    else if (start_i) crc_q <= SEED;
  end

  AST_SEED_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !take_i) |=> (crc_q == SEED)) else $error("seed"); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !take_i) |=> $stable(crc_q)) else $error("hold"); // R8
endmodule

// File: rtl/crc7_result.sv
module crc7_result #(
  parameter int unsigned CW = crc7_pkg::CRC_W,
  localparam int unsigned OW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          finish_i,
  input  logic          en_i,
  input  logic [CW-1:0] crc_i,
  output logic          valid_o,
  output logic [OW-1:0] byte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      byte_o  <= '0;
    end else if (finish_i) begin
      valid_o <= en_i;
      byte_o  <= en_i ? {crc_i, 1'b0} : '0;
    end else if (start_i) begin
      valid_o <= 1'b0;
      byte_o  <= '0;
    end
  end

  AST_BIT0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_o[0] == 1'b0) else $error("bit0"); // R3
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i) |=> (valid_o && $stable(byte_o))) else $error("hold"); // R4
  AST_NO_CSUM_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish_i && !en_i) |=> (!valid_o && byte_o == '0)) else $error("off"); // R7
endmodule

// File: rtl/crc7_cmd_unit.sv
module crc7_cmd_unit #(
  parameter int unsigned CW = crc7_pkg::CRC_W,
  parameter int unsigned DW = crc7_pkg::BYTE_W,
  parameter logic [CW-1:0] POLY = crc7_pkg::CRC_POLY,
  parameter logic [CW-1:0] SEED = crc7_pkg::CRC_SEED,
  localparam int unsigned OW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          last_i,
  input  logic          crc_en_i,
  output logic          ready_o,
  output logic          crc_valid_o,
  output logic [OW-1:0] crc_byte_o
);
  logic          open_q, take, finish;
  logic [CW-1:0] crc_next;

  assign ready_o = open_q | start_i;
  assign take    = valid_i & ready_o;
  assign finish  = take & last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      open_q <= 1'b0;
    else if (finish)  open_q <= 1'b0;
    else if (start_i) open_q <= 1'b1;
  end

  crc7_acc #(.CW(CW), .DW(DW), .POLY(POLY), .SEED(SEED)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .take_i    (take),
    .data_i    (data_i),
    .crc_next_o(crc_next)
  );

  crc7_result #(.CW(CW)) u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .finish_i(finish),
    .en_i    (crc_en_i),
    .crc_i   (crc_next),
    .valid_o (crc_valid_o),
    .byte_o  (crc_byte_o)
  );

  AST_VALID_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && last_i && crc_en_i) |=> crc_valid_o) else $error("late"); // R4
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !(valid_i && last_i)) |=> !crc_valid_o) else $error("clr"); // R6
  AST_CLOSED_IGNORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(crc_byte_o)) else $error("closed"); // R9
  AST_START_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ready_o) else $error("open"); // R5
endmodule

// File: tb/crc7_cmd_unit_bench.sv
module crc7_cmd_unit_bench;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, valid_i = 0, last_i = 0, crc_en_i = 1;
  logic [7:0] data_i = '0;
  logic ready_o, crc_valid_o;
  logic [7:0] crc_byte_o;
  int n_chk = 0, n_err = 0;
  logic [7:0] fr [8];

  always #5 clk_i = ~clk_i;

  crc7_cmd_unit u_crc7_cmd_unit (.*);

  function automatic logic [6:0] model(input int n);
    logic [6:0] r = 7'h7F;
    for (int b = 0; b < n; b++)
      for (int i = 7; i >= 0; i--) begin
        logic fb = r[6] ^ fr[b][i];
        r = {r[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
      end
    return r;
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic vl, input logic [7:0] d, input logic ls);
    @(negedge clk_i);
    start_i = st; valid_i = vl; data_i = d; last_i = ls;
  endtask

  task automatic idle();
    drive(0, 0, 8'h5A, 0);
  endtask

  // sends fr[0..n-1]; start with first byte or on its own; optional gaps
  task automatic send(input int n, input bit sep_start, input bit gaps);
    if (sep_start) drive(1, 0, 8'hEE, 0);
    for (int b = 0; b < n; b++) begin
      drive(b == 0 && !sep_start, 1, fr[b], b == n - 1);
      if (gaps && b != n - 1) begin idle(); idle(); end
    end
    idle();
  endtask

  task automatic t_reset();
    chk("R1 valid", {8'h0, crc_valid_o}, 9'h0);
    chk("R1 byte", {1'b0, crc_byte_o}, 9'h0);
    chk("R1 ready", {8'h0, ready_o}, 9'h0);
  endtask

  task automatic t_known();
    fr[0] = 8'hCA; fr[1] = 0; fr[2] = 0; fr[3] = 0;
    send(4, 0, 0);
    chk("R2 known", {crc_valid_o, crc_byte_o}, {1'b1, 8'hB8});
  endtask

  task automatic t_random(input int reps);
    for (int k = 0; k < reps; k++) begin
      int n = 4 + int'($urandom_range(0, 4));
      for (int b = 0; b < n; b++) fr[b] = 8'($urandom);
      send(n, 0, 0);
      chk("R2 random", {crc_valid_o, crc_byte_o}, {1'b1, model(n), 1'b0});
      chk("R3 bit0", {8'h0, crc_byte_o[0]}, 9'h0);
    end
  endtask

  task automatic t_hold();
    logic [7:0] v;
    fr[0] = 8'h11; fr[1] = 8'h22; fr[2] = 8'h33; fr[3] = 8'h44;
    drive(0, 0, 0, 0);
    send(4, 0, 0);
    chk("R4 valid next cycle", {8'h0, crc_valid_o}, 9'h1);
    v = crc_byte_o;
    repeat (5) idle();
    chk("R4 hold", {crc_valid_o, crc_byte_o}, {1'b1, v});
  endtask

  task automatic t_start_forms();
    logic [7:0] a;
    fr[0] = 8'hC9; fr[1] = 8'h00; fr[2] = 8'h10; fr[3] = 8'h00; fr[4] = 8'hAB;
    send(5, 0, 0); a = crc_byte_o;
    send(5, 1, 0);
    chk("R5 start-with-byte equals start-alone", {1'b0, crc_byte_o}, {1'b0, a});
    chk("R5 model", {1'b0, crc_byte_o}, {1'b0, model(5), 1'b0});
  endtask

  task automatic t_restart();
    drive(1, 0, 0, 0);
    idle();
    chk("R6 start clears valid", {8'h0, crc_valid_o}, 9'h0);
    drive(0, 1, 8'hFF, 0); drive(0, 1, 8'h3C, 0);
    fr[0] = 8'hC4; fr[1] = 8'h80; fr[2] = 8'h24; fr[3] = 8'h00;
    send(4, 0, 0);
    chk("R6 partial discarded", {crc_valid_o, crc_byte_o}, {1'b1, model(4), 1'b0});
  endtask

  task automatic t_disabled();
    fr[0] = 8'hC3; fr[1] = 8'h01; fr[2] = 8'h02; fr[3] = 8'h03;
    crc_en_i = 0;
    send(4, 0, 0);
    chk("R7 off valid", {8'h0, crc_valid_o}, 9'h0);
    chk("R7 off byte", {1'b0, crc_byte_o}, 9'h0);
    crc_en_i = 1;
  endtask

  task automatic t_gaps();
    for (int b = 0; b < 6; b++) fr[b] = 8'($urandom);
    send(6, 0, 1);
    chk("R8 gaps", {crc_valid_o, crc_byte_o}, {1'b1, model(6), 1'b0});
  endtask

  task automatic t_closed();
    logic [7:0] v;
    fr[0] = 8'hC8; fr[1] = 8'h12; fr[2] = 8'h34; fr[3] = 8'h56;
    send(4, 0, 0); v = crc_byte_o;
    drive(0, 1, 8'h99, 0);
    #1 chk("R9 ready low", {8'h0, ready_o}, 9'h0);
    drive(0, 1, 8'h77, 1);
    idle();
    chk("R9 ignored", {crc_valid_o, crc_byte_o}, {1'b1, v});
  endtask

  initial begin
    fork
      begin
        #15 t_reset();
        @(negedge clk_i) rst_ni = 1'b1;
        t_known();
        t_random(12);
        t_hold();
        t_start_forms();
        t_restart();
        t_disabled();
        t_gaps();
        t_closed();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule